// File: doc/BRIEF.md
# Trigger-Started Up-Counting Timer

This block is the time base of a general-purpose timer. A counter runs upward from zero to a programmable period value, then wraps to zero. The wrap is an update event: it sets an overflow flag, and an interrupt output follows that flag while its enable bit is set. Two stages of clock division sit in front of the counter. The first is a fixed ratio of 1, 2 or 4, chosen by a two-bit code. The second is a programmable prescaler that divides by N+1.

Software starts the counter by setting the run bit. In trigger mode, hardware can also start it from a rising edge on an already filtered trigger input. One-shot mode stops the counter at its next update event. The period can go straight into the active register, or it can wait in a buffer until the next update event. A debug pause input freezes the counter and both divider stages. A software event forces an update at once.

Software reaches the block through a single-cycle word register port. The port has a write strobe and a word address, and the read data is combinational.

Top module: `trig_timer`

## Requirements
- R1: After reset every register reads zero. Bits with no field read zero. Register word addresses: 0 control, 1 mode, 2 irq enable, 3 status, 4 software event, 5 counter (read only), 6 prescaler, 7 period. Writing all ones reads back 0x77 at mode and 0x1 at irq enable.
- R2: While control[0] (run) is 1, each tick adds one to the counter. A tick with the counter equal to the active period reloads the counter to 0. That tick is an update event and sets status[0].
- R3: With an active prescaler value N, one tick occurs every N+1 divided clocks. A value written at address 6 becomes active only at the next update event.
- R4: control[5:4] sets a fixed pre-division ahead of the prescaler: 00 gives 1, 01 gives 2, 10 gives 4. The code 11 behaves as 00 but reads back as written.
- R5: When control[2] is 1, a period written at address 7 is held in a buffer and becomes active at the next update event. Reads of address 7 return the written value.
- R6: When control[2] is 0, a written period becomes active on the following clock.
- R7: When control[1] (one-shot) is 1, an update event clears the run bit and the counter stays at 0.
- R8: When mode[6:4] = 3'b110 and mode[2:0] = 3'b101, a rising edge on trig_i sets the run bit. Any other setting leaves the run bit unchanged. A write to control in the same cycle takes priority over the trigger.
- R9: Writing 0 to status[0] clears the flag, and writing 1 leaves it unchanged. An update event in the same cycle wins over the clear. irq_o equals status[0] AND irq-enable[0].
- R10: While dbg_pause_i is 1, the counter and both divider stages hold their values.
- R11: Writing 1 to bit 0 of address 4 forces an update event in the same cycle. The counter and both divider stages reload to 0, the buffered period and the prescaler become active, and the flag is set. Address 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_pause_i | input | 1 | Freezes counting while high |
| trig_i | input | 1 | Filtered trigger input |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with an 8-bit counter (CNT_W = 8). This makes the full-scale period of 255, the counter's natural wrap and every prescaler corner reachable within a few hundred cycles. A behavioural model follows each divider stage, period buffer, run bit and flag. The model predicts the counter and the interrupt on every clock. It covers period rewrites below the live count, pre-division codes changed mid-run, and trigger edges with both matching and non-matching mode settings.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_MODE = 3'd1,
    A_IEN  = 3'd2,
    A_STAT = 3'd3,
    A_SWEV = 3'd4,
    A_CNT  = 3'd5,
    A_PSC  = 3'd6,
    A_PER  = 3'd7
  } reg_addr_e;

  localparam logic [2:0] SLAVE_TRIG = 3'b110;
  localparam logic [2:0] SRC_CH1F   = 3'b101;

  typedef struct packed {
    logic [1:0] clkdiv;
    logic       per_buf;
    logic       one_shot;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/trig_timer_regs.sv
module trig_timer_regs
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              trig_i,
  input  logic              upd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [2:0]        slave_mode_o,
  output logic [2:0]        trig_sel_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              swev_o,
  output logic              per_stb_o,
  output logic [CNT_W-1:0]  psc_wr_o,
  output logic [CNT_W-1:0]  per_wr_o
);
  ctrl_t            ctrl_q;
  logic [2:0]       mode_q, sel_q;
  logic             ien_q, flag_q, trig_q;
  logic [CNT_W-1:0] psc_q, per_q;
  logic             wr_ctrl, wr_mode, wr_ien, wr_stat, wr_psc, wr_per, trig_rise;

  wire unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_mode = we_i && (addr_i == A_MODE);
  assign wr_ien  = we_i && (addr_i == A_IEN);
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_psc  = we_i && (addr_i == A_PSC);
  assign wr_per  = we_i && (addr_i == A_PER);
  assign swev_o  = we_i && (addr_i == A_SWEV) && wdata_i[0];

  assign trig_rise = trig_i && !trig_q && (mode_q == SLAVE_TRIG) && (sel_q == SRC_CH1F);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      sel_q  <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
      psc_q  <= '0;
      per_q  <= '0;
    end else begin
      trig_q <= trig_i;
      // software write beats one-shot clear, which beats trigger set
      if (wr_ctrl) begin
        ctrl_q.run      <= wdata_i[0];
        ctrl_q.one_shot <= wdata_i[1];
        ctrl_q.per_buf  <= wdata_i[2];
        ctrl_q.clkdiv   <= wdata_i[5:4];
      end else if (upd_i && ctrl_q.one_shot) begin
        ctrl_q.run <= 1'b0;
      end else if (trig_rise) begin
        ctrl_q.run <= 1'b1;
      end
      if (wr_mode) begin
        sel_q  <= wdata_i[2:0];
        mode_q <= wdata_i[6:4];
      end
      if (wr_ien) ien_q <= wdata_i[0];
      if (upd_i) flag_q <= 1'b1;
      else if (wr_stat && !wdata_i[0]) flag_q <= 1'b0;
      if (wr_psc) psc_q <= wdata_i[CNT_W-1:0];
      if (wr_per) per_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[0]   = ctrl_q.run;
        rdata_o[1]   = ctrl_q.one_shot;
        rdata_o[2]   = ctrl_q.per_buf;
        rdata_o[5:4] = ctrl_q.clkdiv;
      end
      A_MODE: begin
        rdata_o[2:0] = sel_q;
        rdata_o[6:4] = mode_q;
      end
      A_IEN:   rdata_o[0] = ien_q;
      A_STAT:  rdata_o[0] = flag_q;
      A_CNT:   rdata_o = DATA_W'(cnt_i);
      A_PSC:   rdata_o = DATA_W'(psc_q);
      A_PER:   rdata_o = DATA_W'(per_q);
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o       = ctrl_q;
  assign slave_mode_o = mode_q;
  assign trig_sel_o   = sel_q;
  assign flag_o       = flag_q;
  assign irq_o        = flag_q & ien_q;
  assign per_stb_o    = wr_per;
  assign psc_wr_o     = psc_q;
  assign per_wr_o     = per_q;
endmodule

// File: rtl/trig_timer_presc.sv
module trig_timer_presc #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [1:0]       clkdiv_i,
  input  logic [CNT_W-1:0] psc_wr_i,
  input  logic             upd_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [1:0]       div_q, div_lim;
  logic [CNT_W-1:0] psc_q, psc_act_q;
  logic             div_hit, psc_hit;

  always_comb begin
    unique case (clkdiv_i)
      2'b01:   div_lim = 2'd1;
      2'b10:   div_lim = 2'd3;
      default: div_lim = 2'd0;
    endcase
  end

  assign div_hit = (div_q == div_lim);
  assign psc_hit = (psc_q == psc_act_q);
  assign tick_o  = step_i && div_hit && psc_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      psc_q     <= '0;
      psc_act_q <= '0;
    end else begin
      if (upd_i) psc_act_q <= psc_wr_i;
      if (clr_i) begin
        div_q <= '0;
        psc_q <= '0;
      end else if (step_i) begin
        if (div_hit) begin
          div_q <= '0;
          psc_q <= psc_hit ? '0 : psc_q + 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trig_timer_cnt.sv
module trig_timer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             per_buf_i,
  input  logic             per_stb_i,
  input  logic [CNT_W-1:0] per_din_i,
  input  logic [CNT_W-1:0] per_wr_i,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, per_act_q;

  assign ovf_o = tick_i && (cnt_q == per_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      per_act_q <= '0;
    end else begin
      if (clr_i) cnt_q <= '0;
      else if (tick_i) cnt_q <= ovf_o ? '0 : cnt_q + 1'b1;
      if (per_stb_i && !per_buf_i) per_act_q <= per_din_i;
      else if (upd_i) per_act_q <= per_wr_i;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_pause_i,
  input  logic              trig_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [2:0]       slave_mode, trig_sel;
  logic             ovf_flag, swev, per_stb, tick, ovf, upd, step;
  logic [CNT_W-1:0] cnt, psc_wr, per_wr;

  assign step = ctrl.run && !dbg_pause_i;
  assign upd  = ovf || swev;

  trig_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .trig_i       (trig_i),
    .upd_i        (upd),
    .cnt_i        (cnt),
    .rdata_o      (rdata_o),
    .ctrl_o       (ctrl),
    .slave_mode_o (slave_mode),
    .trig_sel_o   (trig_sel),
    .flag_o       (ovf_flag),
    .irq_o        (irq_o),
    .swev_o       (swev),
    .per_stb_o    (per_stb),
    .psc_wr_o     (psc_wr),
    .per_wr_o     (per_wr)
  );

  trig_timer_presc #(.CNT_W(CNT_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .clkdiv_i (ctrl.clkdiv),
    .psc_wr_i (psc_wr),
    .upd_i    (upd),
    .clr_i    (swev),
    .tick_o   (tick)
  );

  trig_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .clr_i     (swev),
    .upd_i     (upd),
    .per_buf_i (ctrl.per_buf),
    .per_stb_i (per_stb),
    .per_din_i (wdata_i[CNT_W-1:0]),
    .per_wr_i  (per_wr),
    .ovf_o     (ovf),
    .cnt_o     (cnt)
  );
endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dbg_pause_i,
  input logic             trig_i,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             run_i,
  input logic             one_shot_i,
  input logic [2:0]       slave_mode_i,
  input logic [2:0]       trig_sel_i,
  input logic             upd_i,
  input logic             swev_i,
  input logic             flag_i
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == 3'd0);

  a_r10_pause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_pause_i && !swev_i) |=> $stable(cnt_i));

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_i == $past(cnt_i) || cnt_i == CNT_W'($past(cnt_i) + 1'b1) || cnt_i == '0));

  a_r2_ovf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flag_i);

  a_r7_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && one_shot_i && !ctrl_wr) |=> !run_i);

  a_r8_trig_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode_i == 3'b110 && trig_sel_i == 3'b101 && $rose(trig_i) && !ctrl_wr
     && !(upd_i && one_shot_i)) |=> run_i);

  a_r11_swev_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swev_i |=> (cnt_i == '0));
endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dbg_pause_i  (dbg_pause_i),
  .trig_i       (trig_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .cnt_i        (cnt),
  .run_i        (ctrl.run),
  .one_shot_i   (ctrl.one_shot),
  .slave_mode_i (slave_mode),
  .trig_sel_i   (trig_sel),
  .upd_i        (upd),
  .swev_i       (swev),
  .flag_i       (ovf_flag)
);

// File: tb/trig_timer_bench.sv
module trig_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pause = 1'b0;
  logic        trig = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd5;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_timer #(.CNT_W(W)) u_trig_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dbg_pause_i (pause),
    .trig_i      (trig),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .irq_o       (irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model state
  logic         m_run, m_os, m_pb, m_ie, m_flag, m_tq;
  logic [1:0]   m_cdiv, m_divc;
  logic [2:0]   m_tsel, m_smode;
  logic [W-1:0] m_pscw, m_perw, m_psca, m_pera, m_pscc, m_cnt;

  always @(posedge clk) begin
    logic sw, stp, tk, ov, up, tr;
    logic [1:0] lim;
    logic [W-1:0] old_perw, old_pscw;
    if (!rst_n) begin
      {m_run, m_os, m_pb, m_ie, m_flag, m_tq} = '0;
      m_cdiv = '0; m_divc = '0; m_tsel = '0; m_smode = '0;
      m_pscw = '0; m_perw = '0; m_psca = '0; m_pera = '0; m_pscc = '0; m_cnt = '0;
    end else begin
      sw  = we && addr == 3'd4 && wdata[0];
      stp = m_run && !pause;
      lim = (m_cdiv == 2'd1) ? 2'd1 : (m_cdiv == 2'd2) ? 2'd3 : 2'd0;
      tk  = stp && m_divc == lim && m_pscc == m_psca;
      ov  = tk && m_cnt == m_pera;
      up  = ov || sw;
      tr  = trig && !m_tq && m_smode == 3'd6 && m_tsel == 3'd5;
      old_perw = m_perw;
      old_pscw = m_pscw;
      if (sw) begin
        m_cnt = '0; m_divc = '0; m_pscc = '0;
      end else begin
        if (stp) begin
          if (m_divc == lim) begin
            m_divc = '0;
            m_pscc = (m_pscc == m_psca) ? '0 : m_pscc + 1'b1;
          end else m_divc = m_divc + 1'b1;
        end
        if (tk) m_cnt = ov ? '0 : m_cnt + 1'b1;
      end
      if (we && addr == 3'd7 && !m_pb) m_pera = wdata[W-1:0];
      else if (up) m_pera = old_perw;
      if (up) m_psca = old_pscw;
      if (up) m_flag = 1'b1;
      else if (we && addr == 3'd3 && !wdata[0]) m_flag = 1'b0;
      if (we && addr == 3'd0) m_run = wdata[0];
      else if (up && m_os) m_run = 1'b0;
      else if (tr) m_run = 1'b1;
      if (we && addr == 3'd0) begin
        m_os = wdata[1]; m_pb = wdata[2]; m_cdiv = wdata[5:4];
      end
      if (we && addr == 3'd1) begin
        m_tsel = wdata[2:0]; m_smode = wdata[6:4];
      end
      if (we && addr == 3'd2) m_ie = wdata[0];
      if (we && addr == 3'd6) m_pscw = wdata[W-1:0];
      if (we && addr == 3'd7) m_perw = wdata[W-1:0];
      m_tq = trig;
    end
    #2;
    if (rst_n) begin
      if (addr == 3'd5) check(rdata, 32'(m_cnt), cur_req);
      check({31'b0, irq}, {31'b0, m_flag & m_ie}, cur_req);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 3'd5; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    check(rdata, exp, req);
    addr = 3'd5;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1");
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, 32'h77, "R1");
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, 32'h1, "R1");
    wr(3'd1, 0); wr(3'd2, 0);

    cur_req = "R2";
    wr(3'd7, 10); wr(3'd0, 32'h1); idle(40);
    rd(3'd3, 32'h1, "R2");

    cur_req = "R9";
    wr(3'd2, 1);
    @(negedge clk); #1 check({31'b0, irq}, 32'h1, "R9");
    wr(3'd0, 0);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, 32'h1, "R9");
    wr(3'd3, 0); rd(3'd3, 32'h0, "R9");
    #1 check({31'b0, irq}, 32'h0, "R9");

    cur_req = "R3";
    wr(3'd6, 2); wr(3'd0, 1); idle(20);
    cur_req = "R11";
    wr(3'd4, 1); rd(3'd4, 32'h0, "R11");
    cur_req = "R3";
    idle(60);

    cur_req = "R4";
    wr(3'd6, 0); wr(3'd4, 1);
    for (int c = 1; c < 4; c++) begin
      wr(3'd0, 32'((c << 4) | 1));
      rd(3'd0, 32'((c << 4) | 1), "R4");
      idle(50);
    end

    cur_req = "R5";
    wr(3'd0, 32'h5); idle(5);
    wr(3'd7, 3); rd(3'd7, 32'h3, "R5"); idle(40);

    cur_req = "R6";
    wr(3'd0, 32'h1); wr(3'd7, 20); idle(50);
    wr(3'd7, 2); idle(300);

    cur_req = "R10";
    @(negedge clk); pause = 1'b1; #1 v1 = rdata;
    repeat (5) @(negedge clk);
    #1 check(rdata, v1, "R10");
    pause = 1'b0;
    idle(10);

    cur_req = "R7";
    wr(3'd7, 5); wr(3'd0, 32'h3); idle(30);
    rd(3'd0, 32'h2, "R7");
    rd(3'd5, 32'h0, "R7");

    cur_req = "R8";
    wr(3'd0, 0); wr(3'd1, 32'h64);
    @(negedge clk); trig = 1'b1; idle(3);
    rd(3'd0, 32'h0, "R8");
    @(negedge clk); trig = 1'b0;
    wr(3'd1, 32'h65);
    @(negedge clk); trig = 1'b1; idle(2);
    rd(3'd0, 32'h1, "R8");
    @(negedge clk); trig = 1'b0;
    idle(20);

    cur_req = "R2";
    wr(3'd0, 0); wr(3'd7, 255); wr(3'd4, 1); wr(3'd0, 1); idle(600);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule